// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address and the base-register update value for single-word and single-byte load/store instructions. It takes the 32-bit instruction word, the current base register contents, the index register contents, the carry flag and the address of the instruction. From these it produces the access address, the value to write back into the base register, and a flag that says whether that write-back should happen.

The offset is either a 12-bit unsigned immediate or the index register shifted by a 5-bit immediate amount. The offset is added to or subtracted from the base. The addressing mode then decides two things: whether the access uses the raw base (post-indexed) or the adjusted base (pre-indexed or plain offset), and whether the adjusted base is written back. An index form that would need a register-specified shift is flagged as illegal and produces no address. The results are registered and appear one clock after the request.

Top module: `ls_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, out_valid, out_addr, out_wb_val, out_wb_en and out_illegal are all 0.
- R2: A request presented with in_valid=1 at a rising edge shows on the outputs after that edge, with out_valid=1. A cycle with in_valid=0 gives out_valid=0 after the next edge.
- R3: With instr[25]=0 the offset is instr[11:0], zero-extended to 32 bits.
- R4: With instr[25]=1 and instr[4]=0 the offset is idx_val shifted by the amount in instr[11:7]. The shift kind comes from instr[6:5]: 00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right. A logical right shift with amount 0 gives 0, as if the amount were 32.
- R5: An arithmetic right shift with amount 0 fills every bit with idx_val[31]. A rotate with amount 0 gives {carry_in, idx_val[31:1]}.
- R6: instr[23]=1 adds the offset to the base, and instr[23]=0 subtracts it. Both wrap modulo 2^32.
- R7: With instr[24]=0 (post-indexed), out_addr equals the base, out_wb_val equals base plus or minus the offset, and out_wb_en=1 whatever the value of instr[21].
- R8: With instr[24]=1, out_addr and out_wb_val both equal base plus or minus the offset, and out_wb_en equals instr[21].
- R9: When instr[19:16]=15 the base is instr_addr+8 and base_val is ignored. Otherwise the base is base_val.
- R10: instr[25]=1 together with instr[4]=1 gives out_illegal=1, with out_addr=0, out_wb_val=0 and out_wb_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Load/store instruction word |
| base_val | input | 32 | Contents of the base register |
| idx_val | input | 32 | Contents of the index register |
| carry_in | input | 1 | Carry flag, used by the amount-0 rotate |
| instr_addr | input | 32 | Address of the instruction |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Effective access address |
| out_wb_val | output | 32 | Base write-back value |
| out_wb_en | output | 1 | Base write-back enable |
| out_illegal | output | 1 | Index encoding not supported |

## Verification
Every result of this block is due exactly one rising edge after the request is presented: the address, the write-back value, the write-back enable, the illegal flag and out_valid. The bench drives each request on a falling edge. It then reads all five outputs on the following falling edge, half a period after the capturing edge and before the next request could change them. The idle-cycle check of out_valid uses the same one-edge spacing.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

    localparam int XLEN     = 32;
    localparam int IMM_W    = 12;
    localparam int AMT_W    = 5;
    localparam int RIDX_W   = 4;
    localparam int PC_AHEAD = 8;
    localparam logic [RIDX_W-1:0] PC_REG = 4'd15;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic              reg_off;
        logic              pre;
        logic              up;
        logic              wback;
        logic [RIDX_W-1:0] rn;
        logic [AMT_W-1:0]  sh_amt;
        shift_kind_e       sh_kind;
        logic              reg_shift;
        logic [IMM_W-1:0]  imm;
    } ls_fields_t;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wb_val;
        logic            wb_en;
        logic            illegal;
    } agen_result_t;

    function automatic ls_fields_t split_fields(input logic [XLEN-1:0] w);
        ls_fields_t f;
        f.reg_off   = w[25];
        f.pre       = w[24];
        f.up        = w[23];
        f.wback     = w[21];
        f.rn        = w[19:16];
        f.sh_amt    = w[11:7];
        f.sh_kind   = shift_kind_e'(w[6:5]);
        f.reg_shift = w[4];
        f.imm       = w[11:0];
        return f;
    endfunction

    function automatic logic [XLEN-1:0] shift_index(
        input logic [XLEN-1:0]  v,
        input shift_kind_e      kind,
        input logic [AMT_W-1:0] amt,
        input logic             cin
    );
        logic [XLEN-1:0] r;
        logic [AMT_W:0]  back;
        back = 6'(XLEN) - {1'b0, amt};
        unique case (kind)
            SH_LSL: r = v << amt;
            SH_LSR: r = (amt == '0) ? '0 : (v >> amt);
            SH_ASR: r = (amt == '0) ? {XLEN{v[XLEN-1]}}
                                    : XLEN'($signed(v) >>> amt);
            default: r = (amt == '0) ? {cin, v[XLEN-1:1]}
                                     : ((v >> amt) | (v << back));
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsag_offset.sv
module lsag_offset
    import lsag_pkg::*;
(
    input  ls_fields_t      fld,
    input  logic [XLEN-1:0] idx_val,
    input  logic            carry_in,
    output logic [XLEN-1:0] offset,
    output logic            illegal
);
    logic [XLEN-1:0] shifted;

    always_comb begin
        shifted = shift_index(idx_val, fld.sh_kind, fld.sh_amt, carry_in);
        illegal = fld.reg_off & fld.reg_shift;
        if (fld.reg_off) offset = shifted;
        else             offset = {{(XLEN-IMM_W){1'b0}}, fld.imm};
    end

    // R3: the immediate form never carries bits above the 12-bit field
    always_comb begin
        if (!fld.reg_off)
            a_r3_imm_narrow: assert (offset[XLEN-1:IMM_W] == '0);
    end

endmodule

// File: rtl/lsag_mode.sv
module lsag_mode
    import lsag_pkg::*;
(
    input  ls_fields_t      fld,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] instr_addr,
    input  logic [XLEN-1:0] offset,
    input  logic            illegal,
    output logic [XLEN-1:0] base_eff,
    output agen_result_t    res
);
    logic [XLEN-1:0] moved;

    always_comb begin
        base_eff = (fld.rn == PC_REG) ? (instr_addr + XLEN'(PC_AHEAD)) : base_val;
        moved    = fld.up ? (base_eff + offset) : (base_eff - offset);
        res      = '0;
        if (!illegal) begin
            res.addr   = fld.pre ? moved : base_eff;
            res.wb_val = moved;
            res.wb_en  = fld.pre ? fld.wback : 1'b1;
        end
        res.illegal = illegal;
    end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import lsag_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] idx_val,
    input  logic            carry_in,
    input  logic [XLEN-1:0] instr_addr,
    output logic            out_valid,
    output logic [XLEN-1:0] out_addr,
    output logic [XLEN-1:0] out_wb_val,
    output logic            out_wb_en,
    output logic            out_illegal
);
    ls_fields_t      fld;
    logic [XLEN-1:0] offset;
    logic            illegal;
    logic [XLEN-1:0] base_eff;
    agen_result_t    res;
    agen_result_t    res_q;
    logic            valid_q;
    logic            unused_bits;

    assign fld         = split_fields(instr);
    assign unused_bits = ^{instr[31:26], instr[22], instr[20], instr[15:12]};

    lsag_offset u_offset (
        .fld      (fld),
        .idx_val  (idx_val),
        .carry_in (carry_in),
        .offset   (offset),
        .illegal  (illegal)
    );

    lsag_mode u_mode (
        .fld        (fld),
        .base_val   (base_val),
        .instr_addr (instr_addr),
        .offset     (offset),
        .illegal    (illegal),
        .base_eff   (base_eff),
        .res        (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) res_q <= res;
        end
    end

    assign out_valid   = valid_q;
    assign out_addr    = res_q.addr;
    assign out_wb_val  = res_q.wb_val;
    assign out_wb_en   = res_q.wb_en;
    assign out_illegal = res_q.illegal;

    // R7: post-indexed access uses the unmodified base and always writes back
    a_r7_post_base: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !instr[24] && !(instr[25] && instr[4]))
        |=> (out_addr == $past(base_eff)) && out_wb_en);

    // R8: pre-indexed without the write-back bit leaves the base alone
    a_r8_pre_nowb: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[24] && !instr[21]) |=> !out_wb_en);

    // R8: pre-indexed access address equals the write-back value
    a_r8_pre_same: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[24] && !(instr[25] && instr[4]))
        |=> (out_addr == out_wb_val));

    // R10: register-shift index is flagged and suppresses write-back
    a_r10_illegal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[25] && instr[4])
        |=> out_illegal && !out_wb_en && (out_addr == '0));

    // R2: out_valid follows in_valid by one edge
    a_r2_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

endmodule

// File: tb/ls_addr_gen_tb.sv
module ls_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] idx_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] instr_addr = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [31:0] out_wb_val;
    logic        out_wb_en;
    logic        out_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ls_addr_gen dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .base_val(base_val), .idx_val(idx_val), .carry_in(carry_in),
        .instr_addr(instr_addr), .out_valid(out_valid), .out_addr(out_addr),
        .out_wb_val(out_wb_val), .out_wb_en(out_wb_en), .out_illegal(out_illegal)
    );

    function automatic logic [31:0] ref_offset(input logic [31:0] w,
                                               input logic [31:0] x,
                                               input logic c);
        int unsigned n;
        logic [63:0] dbl;
        n = int'(w[11:7]);
        if (!w[25]) return {20'h0, w[11:0]};
        case (w[6:5])
            2'd0: return x << n;
            2'd1: return (n == 0) ? 32'h0 : x >> n;
            2'd2: begin
                if (n == 0) n = 32;
                dbl = {{32{x[31]}}, x};
                return dbl[31:0] >> 0 == 0 ? 32'(dbl >> n) : 32'(dbl >> n);
            end
            default: begin
                if (n == 0) return {c, x[31:1]};
                dbl = {x, x};
                return 32'(dbl >> n);
            end
        endcase
    endfunction

    task automatic check_vec(input string tag, input logic [31:0] w,
                             input logic [31:0] b, input logic [31:0] x,
                             input logic c, input logic [31:0] pc);
        logic [31:0] base, off, moved, e_addr, e_wb;
        logic e_en, e_ill;
        base  = (w[19:16] == 4'd15) ? pc + 32'd8 : b;
        off   = ref_offset(w, x, c);
        moved = w[23] ? base + off : base - off;
        e_ill = w[25] & w[4];
        e_addr = e_ill ? 32'h0 : (w[24] ? moved : base);
        e_wb   = e_ill ? 32'h0 : moved;
        e_en   = e_ill ? 1'b0 : (w[24] ? w[21] : 1'b1);
        @(negedge clk);
        instr = w; base_val = b; idx_val = x; carry_in = c; instr_addr = pc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n_checks++;
        if (!out_valid || out_addr !== e_addr || out_wb_val !== e_wb ||
            out_wb_en !== e_en || out_illegal !== e_ill) begin
            n_fail++;
            $display("FAIL %s instr=%08h: got v=%0b addr=%08h wb=%08h en=%0b ill=%0b exp v=1 addr=%08h wb=%08h en=%0b ill=%0b",
                     tag, w, out_valid, out_addr, out_wb_val, out_wb_en, out_illegal,
                     e_addr, e_wb, e_en, e_ill);
        end
    endtask

    function automatic logic [31:0] mk(input bit i, input bit p, input bit u,
                                       input bit wb, input logic [3:0] rn,
                                       input logic [4:0] amt, input logic [1:0] k,
                                       input bit b4);
        return {4'hE, 2'b01, i, p, u, 1'b0, wb, 1'b1, rn, 4'h3, amt, k, b4, 4'h2};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid || out_addr != 0 || out_wb_val != 0 || out_wb_en || out_illegal) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%0b addr=%08h wb=%08h en=%0b ill=%0b exp all 0",
                     out_valid, out_addr, out_wb_val, out_wb_en, out_illegal);
        end
        rst = 1'b0;

        // R3 immediate, add and subtract
        check_vec("R3 imm add", {4'hE, 8'b0101_1000, 4'h2, 4'h0, 12'hABC}, 32'h1000, 32'h0, 0, 0);
        check_vec("R6 imm sub wrap", {4'hE, 8'b0101_0000, 4'h2, 4'h0, 12'hFFF}, 32'h10, 32'h0, 0, 0);
        // R4 shifts
        check_vec("R4 lsl", mk(1,1,1,0,4'd2,5'd4,2'd0,0), 32'h100, 32'h0F0F_0001, 0, 0);
        check_vec("R4 lsr", mk(1,1,1,0,4'd2,5'd31,2'd1,0), 32'h100, 32'h8000_0000, 0, 0);
        check_vec("R4 lsr zero", mk(1,1,1,0,4'd2,5'd0,2'd1,0), 32'h100, 32'hFFFF_FFFF, 0, 0);
        check_vec("R4 ror", mk(1,1,1,0,4'd2,5'd8,2'd3,0), 32'h0, 32'h1234_5678, 0, 0);
        check_vec("R4 asr", mk(1,1,1,0,4'd2,5'd4,2'd2,0), 32'h0, 32'h8000_0010, 0, 0);
        // R5 amount-0 special cases
        check_vec("R5 asr0 neg", mk(1,1,1,0,4'd2,5'd0,2'd2,0), 32'h5, 32'h8000_0000, 0, 0);
        check_vec("R5 asr0 pos", mk(1,1,1,0,4'd2,5'd0,2'd2,0), 32'h5, 32'h7FFF_FFFF, 0, 0);
        check_vec("R5 rrx c1", mk(1,1,1,0,4'd2,5'd0,2'd3,0), 32'h0, 32'h0000_0003, 1, 0);
        check_vec("R5 rrx c0", mk(1,1,1,0,4'd2,5'd0,2'd3,0), 32'h0, 32'h0000_0003, 0, 0);
        // R7 post-indexed with and without the write-back bit
        check_vec("R7 post w0", mk(0,0,0,0,4'd1,5'd0,2'd0,0), 32'h2000, 32'h0, 0, 0);
        check_vec("R7 post w1", mk(0,0,1,1,4'd1,5'd0,2'd0,0), 32'h2000, 32'h0, 0, 0);
        // R8 pre-indexed with and without write-back
        check_vec("R8 pre w0", mk(0,1,1,0,4'd1,5'd0,2'd0,0), 32'h3000, 32'h0, 0, 0);
        check_vec("R8 pre w1", mk(0,1,0,1,4'd1,5'd0,2'd0,0), 32'h3000, 32'h0, 0, 0);
        // R9 pc-relative base ignores base_val
        check_vec("R9 pc base", mk(0,1,1,0,4'd15,5'd0,2'd0,0), 32'hDEAD_BEEF, 32'h0, 0, 32'h0000_0400);
        check_vec("R9 pc post", mk(0,0,0,0,4'd15,5'd0,2'd0,0), 32'h1234_0000, 32'h0, 0, 32'hFFFF_FFFC);
        // R10 illegal register-shift index
        check_vec("R10 illegal", mk(1,1,1,1,4'd2,5'd3,2'd0,1), 32'h100, 32'h4, 0, 0);
        check_vec("R10 illegal post", mk(1,0,0,0,4'd2,5'd3,2'd1,1), 32'h100, 32'h4, 0, 0);

        // R2 idle cycle drops out_valid
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 idle: got out_valid=%0b exp 0", out_valid);
        end

        // random mix over R3 R4 R5 R6 R7 R8 R9 R10
        begin
            int unsigned seed;
            seed = $urandom(32'h5EED_1234);
            for (int k = 0; k < 400; k++) begin
                logic [31:0] w;
                w = $urandom;
                w[27:26] = 2'b01;
                if (k % 3 != 0) w[4] = 1'b0;
                check_vec("R6 R7 R8 random", w, $urandom, $urandom, 1'($urandom), $urandom);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule